// File: doc/BRIEF.md
# Two-Bank Divided Clock Alignment Strobe Generator

This block takes one fast reference clock and produces two divided clocks, bank A and bank C. Each bank has its own divide ratio, picked from a small set of even integers by a select code. The two banks can run at ratios that are not integer multiples of each other. The block therefore also drives an active-low alignment strobe. The strobe announces the next reference edge on which both bank outputs rise together.

A single counter runs over the common period of the two banks, which is the least common multiple of the two divide values. Count zero is the shared rising edge. The strobe is low for the final stretch of that period. The stretch is as long as one period of the faster bank, so the strobe always ends exactly on a shared rising edge.

Select changes are staged. A new select pair is applied only when the common counter wraps, so no bank output and no strobe is ever cut short. Downstream logic can use the strobe's rising edge to sample data that crosses between the two clock domains.

Top module: `edge_align_gen`

## Requirements
- R1: Select code to divide value, for each bank: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, 4 gives 12. Codes 5, 6 and 7 give 2.
- R2: Each bank output has a 50% duty cycle. For a divide value N it is high for N/2 reference cycles and then low for N/2 cycles. Both bank outputs are high in the first cycle of each common period.
- R3: `alignN` is active low. It is low for exactly min(NA, NC) reference cycles immediately before every rising edge that both bank outputs share.
- R4: When the two divide values differ, `alignN` returns high in the same reference cycle in which both bank outputs rise.
- R5: When the two divide values are equal, `alignN` stays low without interruption.
- R6: While `rst` is sampled high, all counters are held at zero and the select codes are loaded. Both bank outputs then read high, and `alignN` is high unless the divide values are equal.
- R7: A change to either select code while `rst` is low takes effect only on the first cycle of the next common period. The period that is in progress completes with the old ratios.
- R8: The whole output pattern repeats with a period of lcm(NA, NC) reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| selA | input | 3 | Divide select code for bank A |
| selC | input | 3 | Divide select code for bank C |
| clkOutA | output | 1 | Divided clock, bank A |
| clkOutC | output | 1 | Divided clock, bank C |
| alignN | output | 1 | Active-low strobe that ends on the next shared rising edge |

## Verification
Two events can fall in the same cycle: the end of the strobe window at the counter wrap, and the loading of a new select pair. When both happen, the strobe must still rise together with both bank outputs, and the next window must be sized by the new ratios. The bench provokes this by changing the select codes in the middle of a common period, so the wrap that ends the strobe also applies the new pair. It then compares every reference cycle against a model that swaps ratios only at the wrap. It also walks every select pair from reset and checks each strobe rise against a simultaneous rise of both bank outputs.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int SEL_W     = 3;
  localparam int DIV_W     = 4;
  localparam int CNT_W     = 5;
  localparam int NUM_BANKS = 2;
  localparam int LCM_STEPS = 1 << (DIV_W - 1);

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    div_t divA;
    div_t divC;
    cnt_t period;
    cnt_t winStart;
  } cfg_t;

  typedef struct packed {
    logic restart;
    logic cfgLoad;
  } strobe_t;

  function automatic div_t decodeSel(input logic [SEL_W-1:0] code);
    div_t d;
    case (int'(code))
      1:       d = div_t'(4);
      2:       d = div_t'(6);
      3:       d = div_t'(8);
      4:       d = div_t'(12);
      default: d = div_t'(2);
    endcase
    return d;
  endfunction

  function automatic cnt_t lcmOf(input div_t a, input div_t b);
    int acc;
    acc = int'(a);
    for (int i = 0; i < LCM_STEPS; i++) begin
      if ((acc % int'(b)) != 0) acc = acc + int'(a);
    end
    return cnt_t'(acc);
  endfunction

  function automatic cnt_t minOf(input div_t a, input div_t b);
    return (a < b) ? cnt_t'(a) : cnt_t'(b);
  endfunction
endpackage

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
(
  input  logic             rst,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selC,
  input  logic             atEnd,
  output cfg_t             nxtCfg,
  output strobe_t          stb
);
  div_t nxtDivA;
  div_t nxtDivC;
  cnt_t nxtPeriod;
  cnt_t nxtWin;

  always_comb begin
    nxtDivA   = decodeSel(selA);
    nxtDivC   = decodeSel(selC);
    nxtPeriod = lcmOf(nxtDivA, nxtDivC);
    nxtWin    = minOf(nxtDivA, nxtDivC);

    nxtCfg.divA     = nxtDivA;
    nxtCfg.divC     = nxtDivC;
    nxtCfg.period   = nxtPeriod;
    nxtCfg.winStart = nxtPeriod - nxtWin;

    // New ratios and counter restart land together at a period boundary.
    stb.restart = rst | atEnd;
    stb.cfgLoad = rst | atEnd;
  end
endmodule

// File: rtl/align_divider.sv
module align_divider
  import align_pkg::*;
(
  input  logic clk,
  input  logic restart,
  input  div_t div,
  output logic clkOut
);
  div_t phase;

  always_ff @(posedge clk) begin
    if (restart || phase == div_t'(div - div_t'(1))) phase <= '0;
    else                                             phase <= phase + div_t'(1);
  end

  assign clkOut = (phase < (div >> 1));
endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import align_pkg::*;
(
  input  logic    clk,
  input  cfg_t    nxtCfg,
  input  strobe_t stb,
  output cfg_t    curCfg,
  output logic    atEnd,
  output logic    clkOutA,
  output logic    clkOutC,
  output logic    alignN
);
  cnt_t commonCnt;
  div_t bankDiv [NUM_BANKS];
  logic bankOut [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (stb.cfgLoad) curCfg <= nxtCfg;
    if (stb.restart) commonCnt <= '0;
    else             commonCnt <= commonCnt + cnt_t'(1);
  end

  assign atEnd  = (commonCnt == cnt_t'(curCfg.period - cnt_t'(1)));
  assign alignN = (commonCnt < curCfg.winStart);

  assign bankDiv[0] = curCfg.divA;
  assign bankDiv[1] = curCfg.divC;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    align_divider u_div (
      .clk     (clk),
      .restart (stb.restart),
      .div     (bankDiv[g]),
      .clkOut  (bankOut[g])
    );
  end

  assign clkOutA = bankOut[0];
  assign clkOutC = bankOut[1];
endmodule

// File: rtl/edge_align_gen.sv
module edge_align_gen
  import align_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selC,
  output logic             clkOutA,
  output logic             clkOutC,
  output logic             alignN
);
  cfg_t    nxtCfg;
  cfg_t    curCfg;
  strobe_t stb;
  logic    atEnd;

  align_ctrl u_ctrl (
    .rst    (rst),
    .selA   (selA),
    .selC   (selC),
    .atEnd  (atEnd),
    .nxtCfg (nxtCfg),
    .stb    (stb)
  );

  align_datapath u_dp (
    .clk     (clk),
    .nxtCfg  (nxtCfg),
    .stb     (stb),
    .curCfg  (curCfg),
    .atEnd   (atEnd),
    .clkOutA (clkOutA),
    .clkOutC (clkOutC),
    .alignN  (alignN)
  );
endmodule

// File: rtl/edge_align_gen_chk.sv
module edge_align_gen_chk
  import align_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic clkOutA,
  input logic clkOutC,
  input logic alignN,
  input logic atEnd,
  input div_t divA,
  input div_t divC
);
  logic prevRst;

  always_ff @(posedge clk) prevRst <= rst;

  AST_STROBE_ENDS_ON_SHARED_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!prevRst && $rose(alignN)) |-> ($rose(clkOutA) && $rose(clkOutC))); // R4

  AST_SHARED_EDGE_PRECEDED_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!prevRst && $rose(clkOutA) && $rose(clkOutC)) |-> !$past(alignN)); // R3

  AST_BANKS_HIGH_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    atEnd |=> (clkOutA && clkOutC)); // R2

  AST_RATIOS_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (!prevRst && !$past(atEnd)) |-> ($stable(divA) && $stable(divC))); // R7

  AST_EQUAL_RATIO_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
    (divA == divC) |-> !alignN); // R5
endmodule

bind edge_align_gen edge_align_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .clkOutA (clkOutA),
  .clkOutC (clkOutC),
  .alignN  (alignN),
  .atEnd   (atEnd),
  .divA    (curCfg.divA),
  .divC    (curCfg.divC)
);

// File: tb/edge_align_gen_bench.sv
`timescale 1ns/1ps
module edge_align_gen_bench;
  typedef struct {
    bit    expA;
    bit    expC;
    bit    expS;
    bit    afterRst;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] selA = 3'd0;
  logic [2:0] selC = 3'd0;
  logic       clkOutA;
  logic       clkOutC;
  logic       alignN;

  item_t expQ[$];
  int    checks = 0;
  int    failures = 0;
  bit    reported = 0;

  int mCnt = 0, mNa = 2, mNc = 2, mPer = 1, mWin = 2;
  bit prevA = 1'b1, prevC = 1'b1, prevS = 1'b1;

  edge_align_gen u_edge_align_gen (
    .clk     (clk),
    .rst     (rst),
    .selA    (selA),
    .selC    (selC),
    .clkOutA (clkOutA),
    .clkOutC (clkOutC),
    .alignN  (alignN)
  );

  always #10 clk = ~clk;

  // R1 mapping as stated in the requirement.
  function automatic int expDiv(input int code);
    case (code)
      1: return 4;
      2: return 6;
      3: return 8;
      4: return 12;
      default: return 2;
    endcase
  endfunction

  function automatic int expLcm(input int a, input int b);
    int m;
    m = a;
    while ((m % b) != 0) m = m + a;
    return m;
  endfunction

  task automatic finishRun();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: advances the reference model at each edge and queues the expectation.
  task automatic tick(input string tag, input bit afterRst);
    item_t it;
    @(posedge clk);
    if (rst || mCnt == mPer - 1) begin
      mNa  = expDiv(int'(selA));
      mNc  = expDiv(int'(selC));
      mPer = expLcm(mNa, mNc);
      mWin = (mNa < mNc) ? mNa : mNc;
      mCnt = 0;
    end else begin
      mCnt = mCnt + 1;
    end
    #1;
    it.expA     = ((mCnt % mNa) < (mNa / 2));
    it.expC     = ((mCnt % mNc) < (mNc / 2));
    it.expS     = (mCnt < (mPer - mWin));
    it.afterRst = afterRst;
    it.tag      = tag;
    expQ.push_back(it);
  endtask

  task automatic startPair(input int a, input int c);
    rst  = 1'b1;
    selA = 3'(a);
    selC = 3'(c);
    tick("R6", 1'b1);
    tick("R6", 1'b1);
    rst = 1'b0;
  endtask

  // Monitor: pops one expectation per cycle and compares at the falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (clkOutA !== it.expA) begin
        failures++;
        $display("FAIL %s R1 R2 clkOutA act=%b exp=%b", it.tag, clkOutA, it.expA);
      end
      checks++;
      if (clkOutC !== it.expC) begin
        failures++;
        $display("FAIL %s R1 R2 clkOutC act=%b exp=%b", it.tag, clkOutC, it.expC);
      end
      checks++;
      if (alignN !== it.expS) begin
        failures++;
        $display("FAIL %s R3 R5 alignN act=%b exp=%b", it.tag, alignN, it.expS);
      end
      // R4: a strobe rise must coincide with both bank outputs rising.
      if (!it.afterRst && !prevS && alignN === 1'b1) begin
        checks++;
        if (!(!prevA && !prevC && clkOutA === 1'b1 && clkOutC === 1'b1)) begin
          failures++;
          $display("FAIL R4 shared edge act=A%b%b C%b%b exp=A01 C01",
                   prevA, clkOutA, prevC, clkOutC);
        end
      end
      prevA = clkOutA;
      prevC = clkOutC;
      prevS = alignN;
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog run incomplete act=running exp=finished");
    finishRun();
  end

  initial begin
    // Every select pair, including the codes that fall back to divide-by-2.
    for (int a = 0; a < 8; a++) begin
      for (int c = 0; c < 8; c++) begin
        int per;
        per = expLcm(expDiv(a), expDiv(c));
        startPair(a, c);
        repeat (2 * per + 4) tick("R1 R2 R3 R4 R5 R8", 1'b0);
      end
    end

    // R7: changes in the middle of a period are held until the wrap.
    startPair(1, 4);
    repeat (5) tick("R7", 1'b0);
    selA = 3'd0;
    selC = 3'd3;
    repeat (30) tick("R7", 1'b0);
    selA = 3'd2;
    selC = 3'd1;
    repeat (7) tick("R7", 1'b0);
    selA = 3'd3;
    selC = 3'd3;
    repeat (40) tick("R7 R5", 1'b0);

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule